// File: doc/BRIEF.md
# Fetch Source Predictor

This block decides, one cycle ahead, which of three instruction stores the fetch stage should read next: the small line buffer, the cache of already-decoded instructions, or the main instruction cache. Reading the two small stores costs far less energy than the main cache. Guessing one of them when it then misses adds latency, though, so the block picks a small store only when a hit is likely. It never decides by a real lookup.

While fetch stays inside one cache line, the choice follows the store that is serving the current fetch. When fetch moves to a different line, a small direct-mapped table is read. The table remembers, for each current line, where fetch went the last time it left that line. The decoded cache is chosen only when that remembered line carries the same decoded-cache tag as the current address. Every line crossing writes the actual destination line back into the table. The choice is registered, so it appears on the output one clock edge after the fetch that produced it.

Top module: `fsp_fetch_src_pred`

## Requirements
- R1: While reset is asserted and after it is released, `nxt_src` is 2'b10 (main cache) and every prediction table entry is invalid.
- R2: Source codes are 2'b00 line buffer, 2'b01 decoded cache and 2'b10 main cache. On a valid fetch whose next address lies in the same line as the current one (same bits [31:4], 16-byte lines) and whose current source is 2'b00, the selection is 2'b00.
- R3: On a valid same-line fetch with current source 2'b01 and `slot_vld` high, the selection is 2'b01.
- R4: Every other valid same-line fetch selects 2'b10. This covers source 2'b01 with `slot_vld` low, source 2'b10 and the unused code 2'b11.
- R5: On a valid line-crossing fetch, an invalid table entry at the current line's index selects 2'b10.
- R6: On a valid line-crossing fetch with a valid entry, the selection is 2'b01 when the decoded-cache tag (address bits [31:9]) of the current address equals the tag of the entry's stored line. Otherwise it is 2'b10.
- R7: Each valid line-crossing fetch writes the next address's line into the entry at the current line's index and marks it valid. The write takes effect on the same edge as the selection, so the selection uses the entry's previous content.
- R8: The table has 16 entries indexed by address bits [7:4]. Lines sharing these bits share an entry, and writes at one index leave the other indices unchanged.
- R9: When `fetch_vld` is low, `nxt_src` holds its value and the table is not written.
- R10: `nxt_src` changes only at a clock edge and reflects the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_vld | input | 1 | A fetch takes place this cycle |
| cur_addr | input | 32 | Address being fetched now |
| cur_src | input | 2 | Store serving the current fetch |
| slot_vld | input | 1 | Decoded-cache slot for the next instruction holds a valid entry |
| next_addr | input | 32 | Address of the following fetch |
| nxt_src | output | 2 | Registered selection for the next fetch |

## Verification
The properties assume that `fetch_vld`, both addresses, `cur_src` and `slot_vld` are steady around the rising edge, and that `slot_vld` matters only on a same-line fetch from the decoded cache. The stimulus changes every input on the falling edge only. It uses addresses in a narrow window, so that same-line steps, line crossings, tag matches, tag mismatches and index aliasing all occur often. The unused source code 2'b11 and idle cycles that carry crossing addresses are driven on purpose, so the holding rule and the fallback to the main cache are both exercised.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

   typedef enum logic [1:0] {
      SRC_LBUF = 2'b00,
      SRC_DCACHE = 2'b01,
      SRC_ICACHE = 2'b10,
      SRC_RSVD = 2'b11
   } fsp_src_e;

   localparam fsp_src_e SRC_AFTER_RESET = SRC_ICACHE;

endpackage

// File: rtl/fsp_addr_split.sv
module fsp_addr_split #(
   parameter int AW = 32,
   parameter int OFF_W = 4,
   parameter int IDX_W = 4,
   parameter int TAG_LSB = 9
) (
   input  logic [AW-1:0]       addr,
   output logic [AW-OFF_W-1:0] line,
   output logic [IDX_W-1:0]    idx,
   output logic [AW-TAG_LSB-1:0] tag
);
   localparam int LINE_W = AW - OFF_W;

   initial begin : p_param_chk
      assert (OFF_W > 0 && OFF_W < AW) else $fatal(1, "OFF_W out of range");
      assert (TAG_LSB >= OFF_W && TAG_LSB < AW) else $fatal(1, "TAG_LSB out of range");
      assert (IDX_W > 0 && IDX_W <= LINE_W) else $fatal(1, "IDX_W out of range");
   end

   logic unused_offset;
   assign unused_offset = ^addr[OFF_W-1:0];

   assign line = addr[AW-1:OFF_W];
   assign idx  = addr[OFF_W +: IDX_W];
   assign tag  = addr[AW-1:TAG_LSB];

endmodule

// File: rtl/fsp_next_table.sv
module fsp_next_table #(
   parameter int ENTRIES = 16,
   parameter int LINE_W = 28
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [$clog2(ENTRIES)-1:0] rd_idx,
   output logic [LINE_W-1:0]          rd_line,
   output logic                       rd_hit,
   input  logic                       wr_en,
   input  logic [$clog2(ENTRIES)-1:0] wr_idx,
   input  logic [LINE_W-1:0]          wr_line
);
   localparam int IDX_W = $clog2(ENTRIES);

   initial begin : p_param_chk
      assert (ENTRIES >= 2) else $fatal(1, "ENTRIES must be at least 2");
      assert ((1 << IDX_W) == ENTRIES) else $fatal(1, "ENTRIES must be a power of two");
      assert (LINE_W > 0) else $fatal(1, "LINE_W must be positive");
   end

   logic [LINE_W-1:0] ent_line [ENTRIES];
   logic              ent_ok   [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic [LINE_W-1:0] line_q;
      logic              ok_q;
      logic              sel;

      assign sel = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            line_q <= '0;
            ok_q   <= 1'b0;
         end else if (sel) begin
            line_q <= wr_line;
            ok_q   <= 1'b1;
         end
      end

      assign ent_line[e] = line_q;
      assign ent_ok[e]   = ok_q;
   end

   assign rd_line = ent_line[rd_idx];
   assign rd_hit  = ent_ok[rd_idx];

endmodule

// File: rtl/fsp_src_rules.sv
module fsp_src_rules
   import fsp_pkg::*;
(
   input  logic     same_line,
   input  fsp_src_e cur_src,
   input  logic     slot_vld,
   input  logic     pred_ok,
   input  logic     tag_eq,
   output fsp_src_e sel
);
   always_comb begin
      sel = SRC_ICACHE;
      if (same_line) begin
         unique case (cur_src)
            SRC_LBUF:   sel = SRC_LBUF;
            SRC_DCACHE: sel = slot_vld ? SRC_DCACHE : SRC_ICACHE;
            default:    sel = SRC_ICACHE;
         endcase
      end else if (pred_ok && tag_eq) begin
         sel = SRC_DCACHE;
      end
   end

endmodule

// File: rtl/fsp_fetch_src_pred.sv
module fsp_fetch_src_pred
   import fsp_pkg::*;
#(
   parameter int AW = 32,
   parameter int LINE_BYTES = 16,
   parameter int PT_ENTRIES = 16,
   parameter int DC_LINES = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fetch_vld,
   input  logic [AW-1:0] cur_addr,
   input  logic [1:0]    cur_src,
   input  logic          slot_vld,
   input  logic [AW-1:0] next_addr,
   output logic [1:0]    nxt_src
);
   localparam int OFF_W   = $clog2(LINE_BYTES);
   localparam int IDX_W   = $clog2(PT_ENTRIES);
   localparam int TAG_LSB = OFF_W + $clog2(DC_LINES);
   localparam int LINE_W  = AW - OFF_W;
   localparam int TAG_W   = AW - TAG_LSB;

   initial begin : p_param_chk
      assert ((1 << OFF_W) == LINE_BYTES) else $fatal(1, "LINE_BYTES must be a power of two");
      assert ((1 << $clog2(DC_LINES)) == DC_LINES) else $fatal(1, "DC_LINES must be a power of two");
      assert (TAG_LSB < AW) else $fatal(1, "no tag bits left");
   end

   logic [LINE_W-1:0] cur_line, nx_line, pred_line;
   logic [IDX_W-1:0]  cur_idx, unused_nx_idx;
   logic [TAG_W-1:0]  cur_tag, unused_nx_tag, pred_tag;
   logic              pred_ok, same_line, crossing;
   fsp_src_e          sel, src_q;

   fsp_addr_split #(.AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_LSB(TAG_LSB)) u_cur_split (
      .addr (cur_addr),
      .line (cur_line),
      .idx  (cur_idx),
      .tag  (cur_tag)
   );

   fsp_addr_split #(.AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_LSB(TAG_LSB)) u_nx_split (
      .addr (next_addr),
      .line (nx_line),
      .idx  (unused_nx_idx),
      .tag  (unused_nx_tag)
   );

   assign same_line = (cur_line == nx_line);
   assign crossing  = fetch_vld && !same_line;

   fsp_next_table #(.ENTRIES(PT_ENTRIES), .LINE_W(LINE_W)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (cur_idx),
      .rd_line (pred_line),
      .rd_hit  (pred_ok),
      .wr_en   (crossing),
      .wr_idx  (cur_idx),
      .wr_line (nx_line)
   );

   assign pred_tag = pred_line[LINE_W-1 -: TAG_W];

   fsp_src_rules u_rules (
      .same_line (same_line),
      .cur_src   (fsp_src_e'(cur_src)),
      .slot_vld  (slot_vld),
      .pred_ok   (pred_ok),
      .tag_eq    (pred_tag == cur_tag),
      .sel       (sel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         src_q <= SRC_AFTER_RESET;
      else if (fetch_vld) src_q <= sel;
   end

   assign nxt_src = src_q;

endmodule

// File: rtl/fsp_fetch_src_pred_chk.sv
module fsp_fetch_src_pred_chk #(
   parameter int AW = 32,
   parameter int OFF_W = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          fetch_vld,
   input logic [AW-1:0] cur_addr,
   input logic [1:0]    cur_src,
   input logic          slot_vld,
   input logic [AW-1:0] next_addr,
   input logic [1:0]    nxt_src
);
   logic same_ln;
   logic unused_offsets;
   assign same_ln = (cur_addr[AW-1:OFF_W] == next_addr[AW-1:OFF_W]);
   assign unused_offsets = ^{cur_addr[OFF_W-1:0], next_addr[OFF_W-1:0]};

   a_r1_reset_icache: assert property (@(posedge clk)
      !rst_n |=> nxt_src == 2'b10);

   a_r2_stay_lbuf: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_vld && same_ln && cur_src == 2'b00 |=> nxt_src == 2'b00);

   a_r3_stay_dcache: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_vld && same_ln && cur_src == 2'b01 && slot_vld |=> nxt_src == 2'b01);

   a_r4_fallback_icache: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_vld && same_ln && cur_src != 2'b00 && !(cur_src == 2'b01 && slot_vld)
      |=> nxt_src == 2'b10);

   a_r6_cross_no_lbuf: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_vld && !same_ln |=> nxt_src != 2'b00);

   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_vld |=> $stable(nxt_src));

   a_r2_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      nxt_src != 2'b11);

endmodule

bind fsp_fetch_src_pred fsp_fetch_src_pred_chk #(.AW(AW), .OFF_W(OFF_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fetch_vld (fetch_vld),
   .cur_addr  (cur_addr),
   .cur_src   (cur_src),
   .slot_vld  (slot_vld),
   .next_addr (next_addr),
   .nxt_src   (nxt_src)
);

// File: tb/fsp_fetch_src_pred_bench.sv
module fsp_fetch_src_pred_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_vld = 1'b0;
   logic [31:0] cur_addr = '0;
   logic [1:0]  cur_src = '0;
   logic        slot_vld = 1'b0;
   logic [31:0] next_addr = '0;
   logic [1:0]  nxt_src;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   logic [1:0] q_exp [$];
   string      q_tag [$];

   logic [27:0] m_line [16];
   logic        m_ok   [16];
   logic [1:0]  m_hold = 2'b10;

   always #4 clk = ~clk;

   fsp_fetch_src_pred u_fsp_fetch_src_pred (
      .clk (clk), .rst_n (rst_n), .fetch_vld (fetch_vld), .cur_addr (cur_addr),
      .cur_src (cur_src), .slot_vld (slot_vld), .next_addr (next_addr), .nxt_src (nxt_src)
   );

   task automatic check(input logic [1:0] act, input logic [1:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: nxt_src=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic apply(input logic v, input logic [31:0] ca, input logic [1:0] cs,
                        input logic sv, input logic [31:0] na, input string tag);
      logic [1:0] e;
      logic [3:0] ix;
      @(negedge clk);
      fetch_vld = v; cur_addr = ca; cur_src = cs; slot_vld = sv; next_addr = na;
      if (v) begin
         ix = ca[7:4];
         if (ca[31:4] == na[31:4]) begin
            if (cs == 2'b00) e = 2'b00;
            else if (cs == 2'b01 && sv) e = 2'b01;
            else e = 2'b10;
         end else begin
            if (m_ok[ix] && m_line[ix][27:5] == ca[31:9]) e = 2'b01;
            else e = 2'b10;
            m_line[ix] = na[31:4];
            m_ok[ix] = 1'b1;
         end
         #1 check(nxt_src, m_hold, "R10");
         m_hold = e;
      end else begin
         #1 check(nxt_src, m_hold, "R10");
      end
      q_exp.push_back(m_hold);
      q_tag.push_back(tag);
   endtask

   initial begin : monitor
      forever begin
         @(posedge clk);
         #2;
         if (q_exp.size() > 0) check(nxt_src, q_exp.pop_front(), q_tag.pop_front());
      end
   end

   initial begin : watchdog
      #(8 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : driver
      logic [31:0] r;
      for (int i = 0; i < 16; i++) m_ok[i] = 1'b0;
      repeat (3) @(negedge clk);
      check(nxt_src, 2'b10, "R1");
      rst_n = 1'b1;
      @(negedge clk);
      check(nxt_src, 2'b10, "R1");
      // R2 same line, line buffer
      apply(1, 32'h1000, 2'b00, 0, 32'h1004, "R2");
      apply(1, 32'h1000, 2'b00, 1, 32'h100C, "R2");
      // R3 same line, decoded cache with valid slot
      apply(1, 32'h1004, 2'b01, 1, 32'h1008, "R3");
      // R4 other same-line cases
      apply(1, 32'h1004, 2'b01, 0, 32'h1008, "R4");
      apply(1, 32'h1004, 2'b00, 0, 32'h1008, "R2");
      apply(1, 32'h1004, 2'b10, 1, 32'h1008, "R4");
      apply(1, 32'h1004, 2'b00, 0, 32'h1008, "R2");
      apply(1, 32'h1004, 2'b11, 1, 32'h1008, "R4");
      // R5 first crossing, table empty, even though tags agree
      apply(1, 32'h1008, 2'b01, 1, 32'h1010, "R5");
      // R6 R7 entry 0 now holds line 0x101, same tag
      apply(1, 32'h100C, 2'b01, 1, 32'h2000, "R7");
      // R6 entry 0 now holds line 0x200, tag differs
      apply(1, 32'h1000, 2'b01, 1, 32'h1010, "R6");
      // R8 alias at index 0 from a line with another tag
      apply(1, 32'h5000, 2'b01, 1, 32'h5010, "R8");
      // R8 index 3 untouched so far
      apply(1, 32'h1038, 2'b01, 1, 32'h1040, "R8");
      apply(1, 32'h1030, 2'b01, 1, 32'h1040, "R7");
      // R9 idle cycles with crossing addresses
      apply(0, 32'h1030, 2'b00, 0, 32'h9000, "R9");
      apply(0, 32'h1030, 2'b00, 1, 32'h1034, "R9");
      apply(1, 32'h1030, 2'b10, 0, 32'h1040, "R9");
      apply(1, 32'h1030, 2'b00, 0, 32'h1034, "R2");
      apply(1, 32'h1030, 2'b00, 0, 32'h1034, "R2");
      // mixed patterns against the model
      r = 32'h1234_5678;
      for (int i = 0; i < 400; i++) begin
         logic [31:0] ca, na;
         r = r * 32'd1664525 + 32'd1013904223;
         ca = {20'h0, r[11:0]};
         na = r[12] ? ca + 32'd4 : {20'h0, r[27:16]};
         apply(r[30] | r[31], ca, r[14:13], r[15], na, "R6");
      end
      repeat (3) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule